// File: doc/BRIEF.md
# Bandwidth Slot Table Builder

This block turns per-client bandwidth requests into a fixed-length arbitration slot table. It keeps, for each client, a requested slot count and an active flag. A command either claims bandwidth for one client or releases it. A claim is converted to a slot count against a configured full-scale bandwidth, and it is refused if the table cannot hold it. Every accepted command starts a rebuild of the whole table.

A rebuild runs in passes. First, each client with a request gets its slots, placed at even spacing. Next, active clients without a request get one spare slot each, as long as unclaimed capacity is left. Last, every slot that is still empty is dealt round-robin among the active clients. The finished table leaves the block over a write port, one entry per cycle in ascending slot order. A memory arbiter's slot registers are meant to sit behind that port. A busy flag covers the rebuild and a done pulse marks its last entry.

Top module: `slt_table_builder`

## Requirements
- R1: After reset, busy, done, wr_valid and cmd_rejected are low and no client is active. A rebuild started by a release command then streams the empty code (all ones, 15 with 14 clients) in every slot.
- R2: A claim of bandwidth B is converted to a slot count. B = 0 gives 0. Otherwise the count is NUM_SLOTS / (MAX_BW / B), using integer division. If MAX_BW / B is 0, the count is NUM_SLOTS.
- R3: A claim is refused when the sum of the stored counts plus the converted count exceeds NUM_SLOTS. A refusal raises cmd_rejected for one cycle, one cycle after the command. It changes no stored state and starts no rebuild.
- R4: An accepted claim stores the count, marks the client active, and raises busy one cycle after the command.
- R5: Clients are placed in ascending index order. A client with count N aims its k-th slot (k from 0) at k*(NUM_SLOTS/N). If that slot is taken, the client takes the next free slot, wrapping past the last slot to slot 0.
- R6: An active client with a zero count gets exactly one slot, placed like a count of 1. This happens only while spare capacity remains. The spare starts at NUM_SLOTS minus the sum of the counts and decreases by one for each such grant, in index order.
- R7: Slots still empty after placement are filled round-robin over the active clients, in ascending index order. The pointer starts at client 0 on each rebuild and moves past a client only when it fills a slot. With no active client, the slot keeps the empty code.
- R8: A rebuild writes exactly NUM_SLOTS entries, slot 0 to the last slot, on consecutive cycles. done pulses together with the last entry, and busy falls in that same cycle.
- R9: A release clears the client's count and active flag, is never refused, and starts a rebuild.
- R10: A command that arrives while busy is high, or that names a client index of NUM_CLIENTS or above, is ignored. It does not set busy or cmd_rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_release | input | 1 | 1 = release the client, 0 = claim bandwidth |
| cmd_client | input | CLI_W | Client index |
| cmd_bw | input | BW_W | Requested bandwidth (claims only) |
| busy | output | 1 | Rebuild in progress |
| cmd_rejected | output | 1 | One-cycle pulse on a refused claim |
| wr_valid | output | 1 | Table entry valid |
| wr_slot | output | SLOT_W | Slot index of the entry |
| wr_client | output | CLI_W | Client owning the slot, all ones when empty |
| done | output | 1 | Pulse on the last entry of a rebuild |

## Verification
The bench keeps the default 64 slots and 14 clients, so the placement arithmetic is exercised at its real size. MAX_BW is lowered to 1000 so that small bandwidth values give round slot counts: 250 gives 16, 500 gives 32, 100 gives 6, 333 gives 21, and 1 gives 0. Bandwidths above 1000 reach the saturating case. With these values the bench can fill the table to exactly 64, which drains the spare slots that zero-count clients would otherwise receive, and it can push the sum over 64 to force refusals.

// File: rtl/slt_pkg.sv
package slt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_SELECT,
      ST_PROBE,
      ST_FILL
   } slt_state_e;
endpackage

// File: rtl/slt_bw2slots.sv
module slt_bw2slots #(
   parameter int NUM_SLOTS = 64,
   parameter int BW_W      = 32,
   parameter int MAX_BW    = 100_000_000,
   parameter int CNT_W     = 7
) (
   input  logic [BW_W-1:0]  bw,
   output logic [CNT_W-1:0] slots
);
   localparam logic [BW_W-1:0]  MAX_V   = BW_W'(MAX_BW);
   localparam logic [BW_W-1:0]  NSLOT_B = BW_W'(NUM_SLOTS);
   localparam logic [CNT_W-1:0] NSLOT_C = CNT_W'(NUM_SLOTS);

   logic [BW_W-1:0] quot;

   initial begin
      assert (MAX_BW > 0) else $error("MAX_BW must be positive");
      assert (NUM_SLOTS < (1 << CNT_W)) else $error("CNT_W too narrow");
   end

   always_comb begin
      quot  = '0;
      slots = '0;
      if (bw != '0) begin
         quot = MAX_V / bw;
         if (quot == '0) slots = NSLOT_C;
         else            slots = CNT_W'(NSLOT_B / quot);
      end
   end
endmodule

// File: rtl/slt_client_regs.sv
module slt_client_regs #(
   parameter int NUM_CLIENTS = 14,
   parameter int NUM_SLOTS   = 64,
   parameter int CNT_W       = 7,
   parameter int CLI_W       = 4,
   parameter int SUM_W       = 10
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic                              wr_release,
   input  logic [CLI_W-1:0]                  wr_client,
   input  logic [CNT_W-1:0]                  wr_slots,
   output logic [NUM_CLIENTS-1:0][CNT_W-1:0] req_q,
   output logic [NUM_CLIENTS-1:0]            active_q,
   output logic [SUM_W-1:0]                  total
);
   initial begin
      assert (NUM_CLIENTS * NUM_SLOTS < (1 << SUM_W)) else $error("SUM_W too narrow");
   end

   for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q[c]    <= '0;
            active_q[c] <= 1'b0;
         end else if (wr_en && wr_client == CLI_W'(c)) begin
            if (wr_release) begin
               req_q[c]    <= '0;
               active_q[c] <= 1'b0;
            end else begin
               req_q[c]    <= wr_slots;
               active_q[c] <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < NUM_CLIENTS; i++) total = total + SUM_W'(req_q[i]);
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      total <= SUM_W'(NUM_SLOTS)) else $error("slot sum above table size"); // R3
endmodule

// File: rtl/slt_rr_pick.sv
module slt_rr_pick #(
   parameter int N  = 14,
   parameter int IW = 4
) (
   input  logic [N-1:0]  active,
   input  logic [IW-1:0] start,
   output logic          found,
   output logic [IW-1:0] pick
);
   logic [N-1:0][IW-1:0] cand;

   for (genvar off = 0; off < N; off++) begin : g_cand
      assign cand[off] = IW'((int'(start) + off) % N);
   end

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (active[cand[i]]) begin
            found = 1'b1;
            pick  = cand[i];
         end
      end
   end
endmodule

// File: rtl/slt_table_builder.sv
module slt_table_builder #(
   parameter int NUM_SLOTS   = 64,
   parameter int NUM_CLIENTS = 14,
   parameter int BW_W        = 32,
   parameter int MAX_BW      = 100_000_000,
   localparam int SLOT_W     = $clog2(NUM_SLOTS),
   localparam int CLI_W      = $clog2(NUM_CLIENTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_release,
   input  logic [CLI_W-1:0]  cmd_client,
   input  logic [BW_W-1:0]   cmd_bw,
   output logic              busy,
   output logic              cmd_rejected,
   output logic              wr_valid,
   output logic [SLOT_W-1:0] wr_slot,
   output logic [CLI_W-1:0]  wr_client,
   output logic              done
);
   import slt_pkg::*;

   localparam int CNT_W = $clog2(NUM_SLOTS + 1);
   localparam int SUM_W = $clog2(NUM_CLIENTS * NUM_SLOTS + 1);
   localparam logic [CLI_W-1:0]  EMPTY   = {CLI_W{1'b1}};
   localparam logic [CNT_W-1:0]  NSLOT_C = CNT_W'(NUM_SLOTS);
   localparam logic [SLOT_W-1:0] LAST_S  = SLOT_W'(NUM_SLOTS - 1);
   localparam logic [CLI_W-1:0]  LAST_C  = CLI_W'(NUM_CLIENTS - 1);

   initial begin
      assert (NUM_SLOTS >= 2) else $error("NUM_SLOTS too small");
      assert (NUM_CLIENTS >= 2) else $error("NUM_CLIENTS too small");
      assert (NUM_CLIENTS < (1 << CLI_W)) else $error("no room for empty code");
   end

   slt_state_e                        state;
   logic [NUM_SLOTS-1:0][CLI_W-1:0]   table_q;
   logic [CLI_W-1:0]                  cl_q, rr_q;
   logic [CNT_W-1:0]                  need_q, got_q, ivl_q, spare_q;
   logic [SLOT_W-1:0]                 tgt_q, pos_q, s_q;

   logic [CNT_W-1:0]                  new_slots;
   logic [NUM_CLIENTS-1:0][CNT_W-1:0] req_w;
   logic [NUM_CLIENTS-1:0]            active_w;
   logic [SUM_W-1:0]                  total_w;
   logic                              cmd_ok, over, apply;
   logic                              rr_found;
   logic [CLI_W-1:0]                  rr_pick;
   logic [CNT_W-1:0]                  cur_req, eff_n;
   logic [SLOT_W-1:0]                 tgt_next;
   logic [CLI_W-1:0]                  cur_entry;

   slt_bw2slots #(
      .NUM_SLOTS(NUM_SLOTS), .BW_W(BW_W), .MAX_BW(MAX_BW), .CNT_W(CNT_W)
   ) u_conv (
      .bw(cmd_bw), .slots(new_slots)
   );

   slt_client_regs #(
      .NUM_CLIENTS(NUM_CLIENTS), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W),
      .CLI_W(CLI_W), .SUM_W(SUM_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(apply), .wr_release(cmd_release),
      .wr_client(cmd_client), .wr_slots(new_slots),
      .req_q(req_w), .active_q(active_w), .total(total_w)
   );

   slt_rr_pick #(.N(NUM_CLIENTS), .IW(CLI_W)) u_rr (
      .active(active_w), .start(rr_q), .found(rr_found), .pick(rr_pick)
   );

   // admission
   always_comb begin
      cmd_ok = cmd_valid && (state == ST_IDLE) && (cmd_client < CLI_W'(NUM_CLIENTS));
      over   = !cmd_release && ((total_w + SUM_W'(new_slots)) > SUM_W'(NUM_SLOTS));
      apply  = cmd_ok && !over;
   end

   // per-client placement count
   always_comb begin
      cur_req = req_w[cl_q];
      eff_n   = cur_req;
      if (cur_req == '0 && active_w[cl_q] && spare_q != '0) eff_n = CNT_W'(1);
   end

   assign tgt_next  = SLOT_W'(CNT_W'(tgt_q) + ivl_q);
   assign cur_entry = table_q[s_q];
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         table_q      <= {NUM_SLOTS{EMPTY}};
         cl_q         <= '0;
         rr_q         <= '0;
         need_q       <= '0;
         got_q        <= '0;
         ivl_q        <= '0;
         spare_q      <= '0;
         tgt_q        <= '0;
         pos_q        <= '0;
         s_q          <= '0;
         cmd_rejected <= 1'b0;
         wr_valid     <= 1'b0;
         wr_slot      <= '0;
         wr_client    <= '0;
         done         <= 1'b0;
      end else begin
         cmd_rejected <= cmd_ok && over;
         wr_valid     <= 1'b0;
         done         <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (apply) state <= ST_CLEAR;
            end
            ST_CLEAR: begin
               table_q <= {NUM_SLOTS{EMPTY}};
               spare_q <= NSLOT_C - CNT_W'(total_w);
               cl_q    <= '0;
               state   <= ST_SELECT;
            end
            ST_SELECT: begin
               if (eff_n == '0) begin
                  if (cl_q == LAST_C) begin
                     state <= ST_FILL;
                     s_q   <= '0;
                     rr_q  <= '0;
                  end else begin
                     cl_q <= cl_q + 1'b1;
                  end
               end else begin
                  need_q <= eff_n;
                  got_q  <= '0;
                  ivl_q  <= NSLOT_C / eff_n;
                  tgt_q  <= '0;
                  pos_q  <= '0;
                  if (cur_req == '0) spare_q <= spare_q - 1'b1;
                  state  <= ST_PROBE;
               end
            end
            ST_PROBE: begin
               if (table_q[pos_q] == EMPTY) begin
                  table_q[pos_q] <= cl_q;
                  if (got_q + 1'b1 == need_q) begin
                     if (cl_q == LAST_C) begin
                        state <= ST_FILL;
                        s_q   <= '0;
                        rr_q  <= '0;
                     end else begin
                        cl_q  <= cl_q + 1'b1;
                        state <= ST_SELECT;
                     end
                  end else begin
                     got_q <= got_q + 1'b1;
                     tgt_q <= tgt_next;
                     pos_q <= tgt_next;
                  end
               end else begin
                  pos_q <= (pos_q == LAST_S) ? '0 : pos_q + 1'b1;
               end
            end
            ST_FILL: begin
               wr_valid <= 1'b1;
               wr_slot  <= s_q;
               if (cur_entry == EMPTY && rr_found) begin
                  wr_client <= rr_pick;
                  rr_q      <= (rr_pick == LAST_C) ? '0 : rr_pick + 1'b1;
               end else begin
                  wr_client <= cur_entry;
               end
               if (s_q == LAST_S) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  s_q <= s_q + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_SLOT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && $past(wr_valid) |-> wr_slot == SLOT_W'($past(wr_slot) + 1'b1)) else $error("slot order"); // R8
   AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> wr_valid && wr_slot == LAST_S && !busy) else $error("done misplaced"); // R8
   AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rejected |-> !busy) else $error("refusal started a rebuild"); // R3
   AST_PROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_PROBE |-> got_q < need_q) else $error("probe overran count"); // R5
   AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      state != ST_IDLE |=> $stable(total_w) && $stable(active_w)) else $error("state changed in rebuild"); // R10
   AST_FILL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && (|active_w) |-> wr_client < CLI_W'(NUM_CLIENTS)) else $error("empty slot with active client"); // R7
endmodule

// File: tb/sim_slt_table_builder.sv
module sim_slt_table_builder;
   localparam int NS = 64;
   localparam int NC = 14;
   localparam int MAXBW = 1000;
   localparam int EMPTY = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_release = 1'b0;
   logic [3:0]  cmd_client = '0;
   logic [31:0] cmd_bw = '0;
   logic        busy, cmd_rejected, wr_valid, done;
   logic [5:0]  wr_slot;
   logic [3:0]  wr_client;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int exp_slot[$];
   int exp_cli[$];
   int req_m[NC];
   int act_m[NC];
   bit done_seen;
   string cur_tag = "R1";

   always #4 clk = ~clk;

   slt_table_builder #(.NUM_SLOTS(NS), .NUM_CLIENTS(NC), .BW_W(32), .MAX_BW(MAXBW)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_release(cmd_release),
      .cmd_client(cmd_client), .cmd_bw(cmd_bw), .busy(busy), .cmd_rejected(cmd_rejected),
      .wr_valid(wr_valid), .wr_slot(wr_slot), .wr_client(wr_client), .done(done)
   );

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   function automatic int m_slots(int bw);
      int q;
      if (bw == 0) return 0;
      q = MAXBW / bw;
      if (q == 0) return NS;
      return NS / q;
   endfunction

   function automatic int m_sum();
      int s = 0;
      for (int i = 0; i < NC; i++) s += req_m[i];
      return s;
   endfunction

   // driver side: compute the expected table and push it to the scoreboard
   task automatic push_expect();
      int tab[NS];
      int spare, n, ivl, p, rr;
      bit any;
      spare = NS - m_sum();
      for (int s = 0; s < NS; s++) tab[s] = EMPTY;
      for (int c = 0; c < NC; c++) begin
         n = req_m[c];
         if (n == 0) begin
            if (act_m[c] != 0 && spare > 0) begin
               n = 1;
               spare--;
            end
         end
         if (n > 0) begin
            ivl = NS / n;
            for (int k = 0; k < n; k++) begin
               p = k * ivl;
               while (tab[p] != EMPTY) p = (p + 1) % NS;
               tab[p] = c;
            end
         end
      end
      any = 1'b0;
      for (int c = 0; c < NC; c++) if (act_m[c] != 0) any = 1'b1;
      rr = 0;
      for (int s = 0; s < NS; s++) begin
         if (tab[s] == EMPTY && any) begin
            while (act_m[rr] == 0) rr = (rr + 1) % NC;
            tab[s] = rr;
            rr = (rr + 1) % NC;
         end
         exp_slot.push_back(s);
         exp_cli.push_back(tab[s]);
      end
   endtask

   // monitor: compare every streamed entry against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_valid) begin
            if (exp_slot.size() == 0) begin
               chk(1'b0, "R8 unexpected entry", int'(wr_slot), -1);
            end else begin
               int es, ec;
               es = exp_slot.pop_front();
               ec = exp_cli.pop_front();
               chk(int'(wr_slot) == es, "R8 slot index", int'(wr_slot), es);
               chk(int'(wr_client) == ec, {cur_tag, " R5 R6 R7 entry"}, int'(wr_client), ec);
            end
         end
         if (done) begin
            done_seen = 1'b1;
            chk(wr_valid && int'(wr_slot) == NS - 1, "R8 done on last entry", int'(wr_slot), NS - 1);
         end
      end
   end

   task automatic do_cmd(bit rel, int cli, int bw, bit inject, string tag);
      bit valid_cli, accept;
      int sl;
      valid_cli = (cli < NC);
      sl = rel ? 0 : m_slots(bw);
      accept = valid_cli && (rel || (m_sum() + sl <= NS));
      cur_tag = tag;
      @(negedge clk);
      while (busy) @(negedge clk);
      cmd_valid   = 1'b1;
      cmd_release = rel;
      cmd_client  = 4'(cli);
      cmd_bw      = 32'(bw);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == accept, {tag, " R4 R9 R10 busy after command"}, int'(busy), int'(accept));
      chk(cmd_rejected == (valid_cli && !accept), {tag, " R3 R10 refusal pulse"},
          int'(cmd_rejected), int'(valid_cli && !accept));
      if (accept) begin
         if (rel) begin
            req_m[cli] = 0;
            act_m[cli] = 0;
         end else begin
            req_m[cli] = sl;
            act_m[cli] = 1;
         end
         done_seen = 1'b0;
         push_expect();
         if (inject) begin
            // R10: claim for client 9 while busy must leave no trace
            cmd_valid = 1'b1;
            cmd_release = 1'b0;
            cmd_client = 4'd9;
            cmd_bw = 32'd250;
            @(negedge clk);
            cmd_valid = 1'b0;
         end
         while (busy) @(negedge clk);
         @(negedge clk);
         chk(done_seen, {tag, " R8 done seen"}, int'(done_seen), 1);
         chk(exp_slot.size() == 0, {tag, " R8 entry count"}, exp_slot.size(), 0);
      end else begin
         @(negedge clk);
         chk(!busy && !cmd_rejected, {tag, " R3 R10 no rebuild"}, int'(busy), 0);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NC; i++) begin
         req_m[i] = 0;
         act_m[i] = 0;
      end
      repeat (3) @(negedge clk);
      chk(!busy && !wr_valid && !done && !cmd_rejected, "R1 reset outputs", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !wr_valid && !done, "R1 idle after reset", int'(busy), 0);

      do_cmd(1'b1, 3, 0, 1'b0, "R1 R9");          // nothing active: all empty
      do_cmd(1'b0, 0, 250, 1'b0, "R2 R5");        // 16 slots
      do_cmd(1'b0, 2, 100, 1'b0, "R2 R5");        // 6 slots, collisions
      do_cmd(1'b0, 5, 0, 1'b1, "R6 R10");         // zero count, inject while busy
      do_cmd(1'b0, 7, 1000, 1'b0, "R3");          // 22 + 64 refused
      do_cmd(1'b0, 14, 250, 1'b0, "R10");         // out-of-range client
      do_cmd(1'b1, 2, 0, 1'b0, "R9");
      do_cmd(1'b0, 1, 500, 1'b0, "R2 R5");        // 32 slots
      do_cmd(1'b0, 3, 250, 1'b0, "R5 R6");        // sum 64, no spare
      do_cmd(1'b0, 6, 0, 1'b0, "R6");             // active, no spare left
      do_cmd(1'b0, 8, 1, 1'b0, "R2");             // converts to 0 slots
      do_cmd(1'b1, 0, 0, 1'b0, "R9 R6");
      do_cmd(1'b1, 1, 0, 1'b0, "R9 R6");
      do_cmd(1'b1, 3, 0, 1'b0, "R9 R7");
      do_cmd(1'b0, 4, 2000, 1'b0, "R2");          // saturates to 64
      do_cmd(1'b0, 9, 333, 1'b0, "R3");           // 64 + 21 refused

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule